// File: doc/BRIEF.md
# Fine-Adjust Time-of-Day Counter

This block keeps a running time of day for precision time protocol hardware. It holds three fields: seconds, nanoseconds and a 32-bit fraction of a nanosecond. On every clock cycle, which serves as the reference tick, the nanoseconds field moves forward by a fixed nominal step of 8 ns. A signed correction word trims the rate. Its magnitude is added to or subtracted from the fraction on each tick, and a carry or borrow out of the fraction lengthens or shortens that tick's step by one nanosecond. When the nanoseconds field reaches one billion it wraps to the remainder, and the seconds field counts up by one.

Software reaches the block through a small word-addressed register port. Address 0 is the fraction word, address 1 the nanoseconds word, address 2 the seconds word and address 3 the correction word. A read of the fraction word captures the nanoseconds and seconds into shadow copies, so the reads that follow see one consistent instant. A time load is staged by writes to the fraction word (optional) and the nanoseconds word, and it is committed by a write to the seconds word. The live fields are driven out to timestamping and event logic.

Top module: `ptp_tod`

## Requirements
- R1: While reset is asserted, the seconds, nanoseconds and fraction outputs are 0 and the correction word read at address 3 is 0.
- R2: With a correction word of 0, nanoseconds increase by exactly 8 on every clock edge and the fraction does not change.
- R3: With bit 31 of the correction word clear, bits 30:0 (units of 2^-32 ns) are added to the fraction modulo 2^32 on every edge, and a carry out of the fraction makes that edge's step 9 ns.
- R4: With bit 31 of the correction word set, the magnitude is subtracted from the fraction modulo 2^32, and a borrow makes that edge's step 7 ns.
- R5: When a step brings nanoseconds to 1,000,000,000 or more, nanoseconds become the sum minus 1,000,000,000 and seconds increase by one on the same edge.
- R6: A read of address 0 returns the live fraction, and on that edge it captures the live nanoseconds and seconds. Reads of address 1 and address 2 return the captured nanoseconds and seconds.
- R7: The captured values do not change as time advances or when a new time is loaded. They change only at the next read of address 0.
- R8: A write to address 2 (seconds) leaves the counter running for one more edge. The edge after that loads the seconds written, the nanoseconds staged at address 1 and the staged fraction, with no step added.
- R9: When no write to address 0 has been made since the previous load, a load sets the fraction to 0.
- R10: A value written to address 3 reads back unchanged at address 3 and governs the steps from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; each rising edge is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (address 0 read triggers capture) |
| addr | input | 2 | Word address: 0 fraction, 1 nanoseconds, 2 seconds, 3 correction |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| time_sec | output | 32 | Live seconds |
| time_ns | output | 32 | Live nanoseconds |
| time_frac | output | 32 | Live sub-nanosecond fraction |

## Verification
The bench builds the block with its default parameters: a nominal step of 8 ns, a wrap value of one billion and 32-bit words. Reaching the seconds rollover at that real wrap value takes no long run, because the bench loads nanoseconds a few ticks below the boundary and lands both past it and exactly on it. A correction magnitude of a quarter nanosecond makes a carry or borrow occur within four ticks in each direction, so both adjusted step lengths are seen.

// File: rtl/ptp_tod.sv
module ptp_tod #(
  parameter int unsigned W       = 32,
  parameter int unsigned NOM_NS  = 8,
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] time_sec,
  output logic [W-1:0] time_ns,
  output logic [W-1:0] time_frac
);
  localparam logic [W:0] NOM_X  = (W+1)'(NOM_NS);
  localparam logic [W:0] WRAP_X = (W+1)'(NS_WRAP);

  logic [W-1:0] sec_q, ns_q, frac_q, corr_q;
  logic [W-1:0] sh_sec, sh_ns;
  logic [W-1:0] st_sec, st_ns, st_frac;
  logic         load_pend;

  wire         neg  = corr_q[W-1];
  wire [W:0]   mag  = {2'b00, corr_q[W-2:0]};
  wire [W:0]   fsum = neg ? ({1'b0, frac_q} - mag) : ({1'b0, frac_q} + mag);
  wire         cy   = fsum[W];
  wire [W:0]   step = neg ? (NOM_X - (W+1)'(cy)) : (NOM_X + (W+1)'(cy));
  wire [W:0]   nsum = {1'b0, ns_q} + step;
  wire         wrap = nsum >= WRAP_X;
  wire [W:0]   nwr  = nsum - WRAP_X;
  wire [W-1:0] ns_next = wrap ? nwr[W-1:0] : nsum[W-1:0];

  wire wr_frac = wr_en && addr == 2'd0;
  wire wr_ns   = wr_en && addr == 2'd1;
  wire wr_sec  = wr_en && addr == 2'd2;
  wire wr_corr = wr_en && addr == 2'd3;
  wire capture = rd_en && addr == 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_pend) begin
      sec_q  <= st_sec;
      ns_q   <= st_ns;
      frac_q <= st_frac;
    end else begin
      sec_q  <= sec_q + W'(wrap);
      ns_q   <= ns_next;
      frac_q <= fsum[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_q    <= '0;
      st_sec    <= '0;
      st_ns     <= '0;
      st_frac   <= '0;
      load_pend <= 1'b0;
    end else begin
      load_pend <= wr_sec;
      if (wr_corr) corr_q <= wdata;
      if (wr_ns)   st_ns  <= wdata;
      if (wr_sec)  st_sec <= wdata;
      if (wr_frac)        st_frac <= wdata;
      else if (load_pend) st_frac <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_sec <= '0;
      sh_ns  <= '0;
    end else if (capture) begin
      sh_sec <= sec_q;
      sh_ns  <= ns_q;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = frac_q;
      2'd1:    rdata = sh_ns;
      2'd2:    rdata = sh_sec;
      default: rdata = corr_q;
    endcase
  end

  assign time_sec  = sec_q;
  assign time_ns   = ns_q;
  assign time_frac = frac_q;
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned NOM_NS  = 8,
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic [1:0]   addr,
  input logic [W-1:0] time_sec,
  input logic [W-1:0] time_ns,
  input logic         load_pend,
  input logic [W-1:0] sh_sec,
  input logic [W-1:0] sh_ns
);
  assert_step_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pend && time_ns < NS_WRAP - 2*NOM_NS - 2) |=>
      ((time_ns - $past(time_ns)) >= W'(NOM_NS - 1)) &&
      ((time_ns - $past(time_ns)) <= W'(NOM_NS + 1)) && $stable(time_sec));

  assert_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pend && time_ns >= NS_WRAP - NOM_NS + 1 && time_ns < NS_WRAP) |=>
      (time_sec == $past(time_sec) + 1'b1) && (time_ns <= W'(NOM_NS)));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=>
      (sh_ns == $past(time_ns)) && (sh_sec == $past(time_sec)));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == 2'd0) |=> $stable(sh_ns) && $stable(sh_sec));

  assert_load_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> load_pend);
endmodule

bind ptp_tod ptp_tod_chk #(.W(W), .NOM_NS(NOM_NS), .NS_WRAP(NS_WRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .time_sec(time_sec), .time_ns(time_ns), .load_pend(load_pend),
  .sh_sec(sh_sec), .sh_ns(sh_ns)
);

// File: tb/ptp_tod_tb.sv
module ptp_tod_tb;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, time_sec, time_ns, time_frac;

  always #(PERIOD/2) clk = ~clk;

  ptp_tod u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .time_sec(time_sec), .time_ns(time_ns),
    .time_frac(time_frac)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sbq[$];
  sb_item_t cur;
  logic [31:0] act;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      cur = sbq.pop_front();
      case (cur.sel)
        0: act = rdata;
        1: act = time_ns;
        2: act = time_sec;
        default: act = time_frac;
      endcase
      checks++;
      if (act !== cur.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", cur.req, cur.sel, act, cur.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_v(int sel, logic [31:0] e, string req);
    sb_item_t it;
    it.sel = sel; it.exp = e; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic expect_time(logic [31:0] s, logic [31:0] n, logic [31:0] f, string req);
    expect_v(2, s, req);
    expect_v(1, n, req);
    expect_v(3, f, req);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string req);
    rd_en = 1'b1; addr = a;
    expect_v(0, e, req);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic load_time(logic [31:0] s, logic [31:0] n, bit use_f, logic [31:0] f);
    if (use_f) wr(2'd0, f);
    wr(2'd1, n);
    wr(2'd2, s);
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before the sequence ended");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    addr = 2'd3;
    expect_time(0, 0, 0, "R1");
    expect_v(0, 32'h0, "R1");
    tick();
    rst_n = 1'b1;

    // R2 and R8: nominal step and load timing
    load_time(5, 100, 1'b1, 32'h0);
    expect_time(5, 100, 0, "R2");
    repeat (10) tick();
    expect_time(5, 180, 0, "R2");
    wr(2'd1, 777);
    wr(2'd2, 9);
    expect_time(5, 196, 0, "R8");
    tick();
    expect_time(9, 777, 0, "R8");
    tick();

    // R3 and R10: positive correction, quarter ns per tick
    wr(2'd3, 32'h4000_0000);
    load_time(1, 0, 1'b1, 32'h0);
    expect_time(1, 0, 0, "R3");
    repeat (3) tick();
    expect_time(1, 24, 32'hC000_0000, "R3");
    tick();
    expect_time(1, 33, 0, "R3");
    rd(2'd3, 32'h4000_0000, "R10");

    // R4: negative correction
    wr(2'd3, 32'hC000_0000);
    load_time(2, 1000, 1'b1, 32'h0);
    tick();
    expect_time(2, 1007, 32'hC000_0000, "R4");
    repeat (3) tick();
    expect_time(2, 1031, 0, "R4");

    // R5: seconds rollover
    wr(2'd3, 32'h0);
    load_time(7, 999_999_990, 1'b1, 32'h0);
    tick();
    expect_time(7, 999_999_998, 0, "R5");
    tick();
    expect_time(8, 6, 0, "R5");
    load_time(7, 999_999_992, 1'b1, 32'h0);
    tick();
    expect_time(8, 0, 0, "R5");

    // R6: latched read
    load_time(20, 5000, 1'b1, 32'h1234_0000);
    rd(2'd0, 32'h1234_0000, "R6");
    repeat (5) tick();
    rd(2'd1, 5000, "R6");
    rd(2'd2, 20, "R6");

    // R9 and R7: load without fraction, shadow held
    load_time(30, 64, 1'b0, 32'h0);
    expect_time(30, 64, 0, "R9");
    rd(2'd1, 5000, "R7");
    rd(2'd2, 20, "R7");
    rd(2'd0, 32'h0, "R7");
    rd(2'd1, 80, "R7");
    rd(2'd2, 30, "R7");
    tick();

    done = 1;
    finish_run();
  end
endmodule